// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Slave Engine

This block is the bus-facing controller of a 1024-byte serial EEPROM that acts as a slave on a two-wire bus. The SCL and SDA lines are sampled by a system clock that runs at least eight times faster than SCL. The block drives SDA only through an open-drain pull-down. It finds START and STOP conditions and checks the control byte against its device code and a strap input. It then runs byte writes, page writes, current-address reads, random reads and sequential reads.

Memory contents live outside the block. They are reached through a simple synchronous port: a one-cycle read strobe returns data on the next clock, and a one-cycle write strobe stores a byte. A separate write-cycle unit is started by a one-cycle pulse after a STOP that ends a write. While that unit reports busy, the slave gives no acknowledge at all, so a master can poll for completion with a write-mode control byte.

Top module: `eeprom_twi_slave`

## Requirements
- R1: While reset is high and in the first cycles after it, `sda_pull`, `mem_we`, `mem_re` and `prog_start` are all low.
- R2: The slave acknowledges a control byte (bits 7:4 = 1010, bit 3 equal to `strap_hi`, bits 2:1 = block select, bit 0 = 1 for read and 0 for write) only if both the code and the strap bit match. On any mismatch it stays silent until the next START or STOP.
- R3: An acknowledge pulls SDA low for the whole ninth SCL clock of a byte. The pull-down is applied only while SCL is low.
- R4: While `wr_busy` is high, a control byte gets no acknowledge, even if its address matches.
- R5: In a write, the byte after the control byte loads pointer bits [7:0], and the control byte's block bits load pointer bits [9:8]. Each later byte is acknowledged and stored with one single-cycle `mem_we` at the pointer. `mem_we` and `mem_re` are never high together.
- R6: After each stored data byte, only pointer bits [3:0] increment, wrapping within the 16-byte page. Bits [9:4] stay unchanged.
- R7: `prog_start` pulses for one cycle after a STOP, and only if at least one data byte was stored since the last START. A repeated START after the word-address byte gives no pulse and keeps the loaded pointer.
- R8: A read sends the byte at the pointer and then increments the pointer by one, so a read without a word address returns the byte after the last one accessed. The block bits of a read control byte are ignored.
- R9: While the master acknowledges each byte, the slave keeps sending the next byte. The address wraps from 0x3FF to 0x000. After a not-acknowledge, the slave leaves SDA released.
- R10: A START seen in the middle of a byte abandons that byte without a memory write and returns the slave to control-byte reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| strap_hi | input | 1 | Value compared with control-byte bit 3 |
| wr_busy | input | 1 | High while the write-cycle unit is programming |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain enable) |
| prog_start | output | 1 | One-cycle pulse that starts a write cycle |
| mem_addr | output | 10 | Memory port address |
| mem_wdata | output | 8 | Memory port write data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data valid next cycle |
| mem_rdata | input | 8 | Memory read data |

## Verification
A wrong bus-phase state shows on SDA within one SCL period. Typical symptoms are an acknowledge missing or landing in the wrong clock, or a data bit driven one slot early. A bench master sees this on the very next byte. A wrong pointer only shows when it is used: on the next stored byte, or on the first byte of the next read. The page-wrap, array-wrap and current-read scenarios therefore place their addresses right at those edges. A lost or extra write-cycle pulse shows as a missing busy window, or as acknowledge polling that never fails.

// File: rtl/eeprom_slv_pkg.sv
package eeprom_slv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_WADDR, ST_WDATA, ST_RDATA, ST_RACK, ST_IGNORE
  } slv_state_t;

  typedef enum logic [1:0] {
    PH_BITS, PH_ACK, PH_REL
  } slv_phase_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_prev;
  logic sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/eeprom_addr_ptr.sv
module eeprom_addr_ptr #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_page,
  input  logic              step_full,
  output logic [ADDR_W-1:0] ptr
);
  logic [PAGE_W-1:0] lo_next;
  assign lo_next = ptr[PAGE_W-1:0] + PAGE_W'(1);

  always_ff @(posedge clk) begin
    if (rst)            ptr <= '0;
    else if (load)      ptr <= load_val;
    else if (step_page) ptr <= {ptr[ADDR_W-1:PAGE_W], lo_next};
    else if (step_full) ptr <= ptr + ADDR_W'(1);
  end
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
  import eeprom_slv_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int BLK_W       = 2,
  parameter int PAGE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              strap_hi,
  input  logic              wr_busy,
  output logic              sda_pull,
  output logic              prog_start,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [7:0]        mem_rdata
);
  localparam int LO_W = ADDR_W - BLK_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  twi_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_lvl(scl_s), .sda_lvl(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  slv_state_t        state, nstate;
  slv_phase_t        phase;
  logic [2:0]        bitcnt;
  logic [6:0]        rx_sr;
  logic [7:0]        tx_sr;
  logic              ack_q, wrote, re_q;
  logic [BLK_W-1:0]  blk_q;
  logic [ADDR_W-1:0] ptr;

  logic [7:0] rx_byte;
  logic byte_end, ctrl_hit, waddr_end, wdata_end, rd_first, rd_next;

  always_comb begin
    rx_byte   = {rx_sr, sda_s};
    byte_end  = scl_rise && (phase == PH_BITS) && (bitcnt == 3'd7);
    ctrl_hit  = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3] == strap_hi) && !wr_busy;
    waddr_end = byte_end && (state == ST_WADDR);
    wdata_end = byte_end && (state == ST_WDATA);
    rd_first  = byte_end && (state == ST_CTRL) && ctrl_hit && rx_byte[0];
    rd_next   = scl_rise && (state == ST_RACK) && (phase == PH_ACK) && !sda_s;
  end

  eeprom_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ptr (
    .clk(clk), .rst(rst), .load(waddr_end),
    .load_val({blk_q, rx_byte[LO_W-1:0]}),
    .step_page(wdata_end), .step_full(rd_first || rd_next), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      nstate     <= ST_IDLE;
      phase      <= PH_BITS;
      bitcnt     <= '0;
      rx_sr      <= '0;
      tx_sr      <= '1;
      ack_q      <= 1'b0;
      wrote      <= 1'b0;
      re_q       <= 1'b0;
      blk_q      <= '0;
      sda_pull   <= 1'b0;
      prog_start <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      prog_start <= 1'b0;
      re_q       <= mem_re;
      if (re_q) tx_sr <= mem_rdata;

      if (start_det) begin
        state    <= ST_CTRL;
        phase    <= PH_BITS;
        bitcnt   <= '0;
        sda_pull <= 1'b0;
        wrote    <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        phase      <= PH_BITS;
        sda_pull   <= 1'b0;
        prog_start <= wrote;
        wrote      <= 1'b0;
      end else if (scl_rise) begin
        case (state)
          ST_CTRL, ST_WADDR, ST_WDATA: begin
            if (phase == PH_BITS) begin
              rx_sr  <= rx_byte[6:0];
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                phase <= PH_ACK;
                ack_q <= 1'b1;
                if (state == ST_CTRL) begin
                  if (ctrl_hit) begin
                    blk_q <= rx_byte[BLK_W:1];
                    if (rx_byte[0]) begin
                      nstate   <= ST_RDATA;
                      mem_re   <= 1'b1;
                      mem_addr <= ptr;
                    end else begin
                      nstate <= ST_WADDR;
                    end
                  end else begin
                    ack_q  <= 1'b0;
                    nstate <= ST_IGNORE;
                  end
                end else if (state == ST_WADDR) begin
                  nstate <= ST_WDATA;
                end else begin
                  nstate    <= ST_WDATA;
                  mem_we    <= 1'b1;
                  mem_addr  <= ptr;
                  mem_wdata <= rx_byte;
                  wrote     <= 1'b1;
                end
              end
            end else if (phase == PH_ACK) begin
              phase <= PH_REL;
            end
          end
          ST_RDATA: begin
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              state <= ST_RACK;
              phase <= PH_ACK;
            end
          end
          ST_RACK: begin
            if (phase == PH_ACK) begin
              if (!sda_s) begin
                mem_re   <= 1'b1;
                mem_addr <= ptr;
                phase    <= PH_REL;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end else if (scl_fall) begin
        case (state)
          ST_CTRL, ST_WADDR, ST_WDATA: begin
            if (phase == PH_ACK) begin
              sda_pull <= ack_q;
            end else if (phase == PH_REL) begin
              state    <= nstate;
              phase    <= PH_BITS;
              bitcnt   <= '0;
              sda_pull <= (nstate == ST_RDATA) ? ~tx_sr[7] : 1'b0;
            end
          end
          ST_RDATA: begin
            tx_sr    <= {tx_sr[6:0], 1'b1};
            sda_pull <= ~tx_sr[6];
          end
          ST_RACK: begin
            if (phase == PH_ACK) begin
              sda_pull <= 1'b0;
            end else if (phase == PH_REL) begin
              state    <= ST_RDATA;
              phase    <= PH_BITS;
              bitcnt   <= '0;
              sda_pull <= ~tx_sr[7];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_twi_slave_chk.sv
module eeprom_twi_slave_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_pull,
  input logic prog_start,
  input logic mem_we,
  input logic mem_re
);
  AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s); // R3
  AST_PROG_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> $past(stop_det)); // R7
  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull); // R10
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re)); // R5
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !sda_pull && !mem_we && !mem_re && !prog_start); // R1
endmodule

bind eeprom_twi_slave eeprom_twi_slave_chk i_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_pull(sda_pull), .prog_start(prog_start),
  .mem_we(mem_we), .mem_re(mem_re)
);

// File: tb/test_eeprom_twi_slave.sv
module test_eeprom_twi_slave;
  localparam int Q        = 5;
  localparam int BUSY_CYC = 1500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_in = 1'b1;
  logic sda_m = 1'b1;
  logic strap_hi = 1'b1;
  logic wr_busy;
  logic sda_pull, prog_start, mem_we, mem_re;
  logic [9:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0;
  int errors = 0;
  int prog_cnt = 0;
  int busy_cnt = 0;
  logic [7:0] mem_model [1024];

  always #10 clk = ~clk;

  eeprom_twi_slave i_eeprom_twi_slave (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_bus),
    .strap_hi(strap_hi), .wr_busy(wr_busy), .sda_pull(sda_pull),
    .prog_start(prog_start), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem_model[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem_model[mem_addr];
    if (rst) busy_cnt <= 0;
    else if (prog_start) begin
      busy_cnt <= BUSY_CYC;
      prog_cnt <= prog_cnt + 1;
    end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
  end
  assign wr_busy = (busy_cnt != 0);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic start_cond;
    scl_in = 1'b0; hq; sda_m = 1'b1; hq; scl_in = 1'b1; hq; hq;
    sda_m = 1'b0; hq; hq; scl_in = 1'b0; hq;
  endtask

  task automatic stop_cond;
    scl_in = 1'b0; hq; sda_m = 1'b0; hq; scl_in = 1'b1; hq; hq;
    sda_m = 1'b1; hq; hq;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      hq; sda_m = b[7-i]; hq; scl_in = 1'b1; hq; hq; scl_in = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    hq; sda_m = 1'b1; hq; scl_in = 1'b1; hq; ack = !sda_bus; hq; scl_in = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      hq; sda_m = 1'b1; hq; scl_in = 1'b1; hq; b[7-i] = sda_bus; hq; scl_in = 1'b0;
    end
    hq; sda_m = !give_ack; hq; scl_in = 1'b1; hq; hq; scl_in = 1'b0;
  endtask

  task automatic wait_idle;
    while (wr_busy) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 sda_pull", sda_pull, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 mem_re", mem_re, 0);
    chk("R1 prog_start", prog_start, 0);
  endtask

  task automatic t_addr_match;
    bit a;
    int p0 = prog_cnt;
    start_cond; send_byte(8'hA0, a); stop_cond; chk("R2 strap mismatch nack", a, 0);
    start_cond; send_byte(8'hB8, a); stop_cond; chk("R2 code mismatch nack", a, 0);
    start_cond; send_byte(8'hA8, a); stop_cond; chk("R2 match ack", a, 1);
    repeat (5) @(negedge clk);
    chk("R7 no pulse without data", prog_cnt, p0);
  endtask

  task automatic t_byte_write;
    bit a0, a1, a2;
    int p0 = prog_cnt;
    start_cond; send_byte(8'hA8, a0); send_byte(8'h10, a1); send_byte(8'h5A, a2);
    chk("R3 ack ctrl", a0, 1); chk("R3 ack waddr", a1, 1); chk("R5 ack data", a2, 1);
    stop_cond;
    repeat (5) @(negedge clk);
    chk("R7 one pulse after stop", prog_cnt, p0 + 1);
    chk("R5 stored byte", mem_model[10'h010], 8'h5A);
  endtask

  task automatic t_poll;
    bit a;
    start_cond; send_byte(8'hA8, a); stop_cond; chk("R4 nack while busy", a, 0);
    wait_idle;
    start_cond; send_byte(8'hA8, a); stop_cond; chk("R4 ack after busy", a, 1);
  endtask

  task automatic t_page_wrap;
    bit a;
    wait_idle;
    start_cond; send_byte(8'hAC, a); send_byte(8'h3E, a);
    send_byte(8'h11, a); send_byte(8'h22, a); send_byte(8'h33, a);
    chk("R6 ack last byte", a, 1);
    stop_cond;
    repeat (5) @(negedge clk);
    chk("R6 byte at 23E", mem_model[10'h23E], 8'h11);
    chk("R6 byte at 23F", mem_model[10'h23F], 8'h22);
    chk("R6 wrap to 230", mem_model[10'h230], 8'h33);
    chk("R6 240 untouched", mem_model[10'h240], pat(10'h240));
  endtask

  task automatic t_random_read;
    bit a;
    logic [7:0] d;
    int p0;
    wait_idle;
    p0 = prog_cnt;
    start_cond; send_byte(8'hAC, a); send_byte(8'h3E, a);
    start_cond; send_byte(8'hAD, a); chk("R2 read ctrl ack", a, 1);
    recv_byte(1'b0, d); stop_cond;
    chk("R8 random read data", d, 8'h11);
    repeat (5) @(negedge clk);
    chk("R7 repeated start no pulse", prog_cnt, p0);
  endtask

  task automatic t_current_read;
    bit a;
    logic [7:0] d;
    start_cond; send_byte(8'hA9, a); recv_byte(1'b0, d); stop_cond;
    chk("R8 current read next addr", d, 8'h22);
  endtask

  task automatic t_seq_wrap;
    bit a;
    logic [7:0] d0, d1, d2;
    start_cond; send_byte(8'hAE, a); send_byte(8'hFE, a);
    start_cond; send_byte(8'hAF, a);
    recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
    hq; hq;
    chk("R9 released after nack", sda_pull, 0);
    stop_cond;
    chk("R9 byte 3FE", d0, pat(10'h3FE));
    chk("R9 byte 3FF", d1, pat(10'h3FF));
    chk("R9 wrap to 000", d2, pat(0));
  endtask

  task automatic t_abort;
    bit a;
    logic [7:0] d;
    int p0 = prog_cnt;
    start_cond; send_byte(8'hA8, a); send_byte(8'h20, a);
    send_bits(8'hF0, 4);
    start_cond; send_byte(8'hA9, a);
    chk("R10 ctrl ack after abort", a, 1);
    recv_byte(1'b0, d); stop_cond;
    chk("R10 pointer kept, data intact", d, pat(10'h020));
    chk("R10 no write", mem_model[10'h020], pat(10'h020));
    repeat (5) @(negedge clk);
    chk("R10 no pulse", prog_cnt, p0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem_model[i] = pat(i);
    repeat (5) @(negedge clk);
    t_reset;
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset;
    t_addr_match;
    t_byte_write;
    t_poll;
    t_page_wrap;
    t_random_read;
    t_current_read;
    t_seq_wrap;
    t_abort;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule